// File: doc/BRIEF.md
# Floppy Bit-Cell Word Framer

This block sits behind a floppy drive read head. Once per bit cell it samples a serial data line and moves the sample into a shift register. It hands the assembled word to the rest of the chip each time a full word has been collected. The bit-cell period comes from a free-running 1 MHz tick input. The cell lasts either two or four ticks, and a bit in the control register picks which.

Software controls the block through two write targets that share one data bus, selected by a single select line. The first target is a 16-bit control register. Each write either sets or clears the bits marked in the written value. The second target is the sync pattern. The control register can be read back at all times.

When pattern matching is switched on, a match between the shift register and the stored pattern raises a one-cycle flag. The match also restarts the word boundary, so the next word covers exactly the bits that follow the pattern. The encoding-mode field, the precompensation field and the MSB-sync request are stored and read back, but they do not change how data is received.

Top module: `fdd_word_framer`

## Requirements
- R1: After reset, `ctrl_rdata` is 0, `word_valid`, `sync_hit` and `bit_strobe` are low, the sync pattern is 0, and pattern matching is off.
- R2: A write with `wr_sel`=0 updates the control register. If `wr_data[15]`=1, every bit that is 1 in `wr_data[14:0]` is set. If `wr_data[15]`=0, every such bit is cleared. Bits that are 0 in `wr_data` keep their value. All of bits 14:0 are stored and read back on `ctrl_rdata` from the cycle after the write, including bit 9 (MSB sync), bit 12 (encoding mode) and bits 14:13 (precompensation). Without a write, `ctrl_rdata` does not change.
- R3: Bit 15 of `ctrl_rdata` always reads 0.
- R4: `bit_strobe` is high only in a cycle where `tick_in` is high. In steady state it fires on every 2nd tick when control bit 8 is 1, and on every 4th tick when control bit 8 is 0.
- R5: A change of control bit 8 restarts the cell timer. Counting the ticks after the write cycle, the first strobe falls on tick number 2 (bit 8 = 1) or tick number 4 (bit 8 = 0).
- R6: `rx_bit` is sampled at the clock edge where `bit_strobe` is high and enters bit 0 of the shift register. Older bits move toward the MSB, so `word_data[15]` holds the oldest bit of the word.
- R7: With matching off, `word_valid` pulses for one cycle, in the cycle after every 16th sampled bit counted from reset. In that cycle `word_data` carries the 16 most recent bits.
- R8: With control bit 10 set, a sample that makes the shift register equal to the sync pattern raises `sync_hit` for one cycle, in the next cycle. That sample produces no word. The next `word_valid` follows the 16th sample after the match. `word_valid` and `sync_hit` are never high together.
- R9: With control bit 10 clear, `sync_hit` stays low, and a stream that contains the pattern is framed as ordinary data.
- R10: A write with `wr_sel`=1 loads the sync pattern from `wr_data` and leaves `ctrl_rdata` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_in | input | 1 | One-cycle pulse at 1 MHz |
| rx_bit | input | 1 | Serial read data from the drive |
| wr_en | input | 1 | Register write enable |
| wr_sel | input | 1 | 0 = control register, 1 = sync pattern |
| wr_data | input | 16 | Register write data |
| ctrl_rdata | output | 16 | Control register readback |
| bit_strobe | output | 1 | Bit-cell sampling strobe |
| word_valid | output | 1 | One-cycle word-ready pulse |
| word_data | output | 16 | Assembled word |
| sync_hit | output | 1 | One-cycle sync-match pulse |

## Verification
The bench uses the default parameters: a 16-bit word and cell periods of two and four ticks. It pulses `tick_in` on every fourth clock, so one bit cell lasts 8 or 16 clocks. That makes both rate settings, both timer restarts and dozens of complete words fit easily in one run. The sync pattern is placed after five stray bits, which puts it off the free-running word boundary, so realignment and the first word after the match can be observed directly.

// File: rtl/fwf_pkg.sv
package fwf_pkg;
   localparam int REG_W       = 16;
   localparam int BIT_OP      = 15;  // set (1) / clear (0) selector in writes
   localparam int BIT_RATE    = 8;   // 1: short cell, 0: long cell
   localparam int BIT_MSBSYNC = 9;   // stored only
   localparam int BIT_SYNC_EN = 10;  // enable pattern alignment
   localparam int BIT_ENC     = 12;  // stored only

   typedef enum logic {
      SEL_CTRL = 1'b0,
      SEL_SYNC = 1'b1
   } wr_target_e;

   typedef struct packed {
      logic fast_cell;
      logic sync_en;
   } rx_mode_t;
endpackage

// File: rtl/fwf_regs.sv
module fwf_regs
   import fwf_pkg::*;
#(
   parameter int WORD_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              wr_sel,
   input  logic [REG_W-1:0]  wr_data,
   output logic [REG_W-1:0]  ctrl_q,
   output logic [WORD_W-1:0] sync_q,
   output rx_mode_t          mode
);
   logic              ctrl_hit;
   logic              sync_wr;
   logic [REG_W-1:0]  ctrl_d;

   assign ctrl_hit = wr_en && (wr_target_e'(wr_sel) == SEL_CTRL);
   assign sync_wr  = wr_en && (wr_target_e'(wr_sel) == SEL_SYNC);

   genvar b;
   generate
      for (b = 0; b < REG_W; b++) begin : g_bit
         if (b == BIT_OP) begin : g_op
            assign ctrl_d[b] = 1'b0;
         end else begin : g_store
            assign ctrl_d[b] = (ctrl_hit && wr_data[b]) ? wr_data[BIT_OP] : ctrl_q[b];
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
      end else begin
         ctrl_q <= ctrl_d;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= '0;
      end else if (sync_wr) begin
         sync_q <= wr_data[WORD_W-1:0];
      end
   end

   assign mode.fast_cell = ctrl_q[BIT_RATE];
   assign mode.sync_en   = ctrl_q[BIT_SYNC_EN];
endmodule

// File: rtl/fwf_cell_timer.sv
module fwf_cell_timer #(
   parameter int FAST_TICKS = 2,
   parameter int SLOW_TICKS = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic fast,
   output logic strobe
);
   localparam int MAX_TICKS = (FAST_TICKS > SLOW_TICKS) ? FAST_TICKS : SLOW_TICKS;
   localparam int TW        = (MAX_TICKS > 1) ? $clog2(MAX_TICKS) : 1;

   generate
      if (FAST_TICKS < 1 || SLOW_TICKS < 1) begin : g_bad_period
         $error("cell periods must be at least one tick");
      end
   endgenerate

   logic [TW-1:0] cnt_q;
   logic [TW-1:0] last_cnt;
   logic          fast_q;
   logic          restart;

   assign last_cnt = fast ? TW'(FAST_TICKS - 1) : TW'(SLOW_TICKS - 1);
   assign restart  = (fast != fast_q);
   assign strobe   = tick && !restart && (cnt_q == last_cnt);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         fast_q <= 1'b0;
      end else begin
         fast_q <= fast;
         if (restart) begin
            cnt_q <= '0;
         end else if (tick) begin
            cnt_q <= (cnt_q == last_cnt) ? '0 : cnt_q + 1'b1;
         end
      end
   end
endmodule

// File: rtl/fwf_framer.sv
module fwf_framer #(
   parameter int WORD_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              strobe,
   input  logic              rx_bit,
   input  logic              sync_en,
   input  logic [WORD_W-1:0] sync_word,
   output logic              word_valid,
   output logic [WORD_W-1:0] word_data,
   output logic              sync_hit
);
   localparam int CW = $clog2(WORD_W);

   generate
      if (WORD_W < 2) begin : g_bad_width
         $error("word width must be at least two bits");
      end
   endgenerate

   logic [WORD_W-1:0] shift_q;
   logic [WORD_W-1:0] shifted;
   logic [CW-1:0]     cnt_q;
   logic              match;
   logic              last;

   assign shifted = {shift_q[WORD_W-2:0], rx_bit};
   assign match   = sync_en && (shifted == sync_word);
   assign last    = (cnt_q == CW'(WORD_W - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shift_q    <= '0;
         cnt_q      <= '0;
         word_valid <= 1'b0;
         word_data  <= '0;
         sync_hit   <= 1'b0;
      end else begin
         word_valid <= 1'b0;
         sync_hit   <= 1'b0;
         if (strobe) begin
            shift_q <= shifted;
            if (match) begin
               cnt_q    <= '0;
               sync_hit <= 1'b1;
            end else begin
               cnt_q <= last ? '0 : cnt_q + 1'b1;
               if (last) begin
                  word_valid <= 1'b1;
                  word_data  <= shifted;
               end
            end
         end
      end
   end
endmodule

// File: rtl/fdd_word_framer.sv
module fdd_word_framer
   import fwf_pkg::*;
#(
   parameter int WORD_W     = 16,
   parameter int FAST_TICKS = 2,
   parameter int SLOW_TICKS = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_in,
   input  logic              rx_bit,
   input  logic              wr_en,
   input  logic              wr_sel,
   input  logic [REG_W-1:0]  wr_data,
   output logic [REG_W-1:0]  ctrl_rdata,
   output logic              bit_strobe,
   output logic              word_valid,
   output logic [WORD_W-1:0] word_data,
   output logic              sync_hit
);
   generate
      if (WORD_W > REG_W) begin : g_bad_word
         $error("word width cannot exceed the register bus width");
      end
   endgenerate

   logic [WORD_W-1:0] sync_word;
   rx_mode_t          mode;

   fwf_regs #(.WORD_W(WORD_W)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_sel  (wr_sel),
      .wr_data (wr_data),
      .ctrl_q  (ctrl_rdata),
      .sync_q  (sync_word),
      .mode    (mode)
   );

   fwf_cell_timer #(.FAST_TICKS(FAST_TICKS), .SLOW_TICKS(SLOW_TICKS)) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick   (tick_in),
      .fast   (mode.fast_cell),
      .strobe (bit_strobe)
   );

   fwf_framer #(.WORD_W(WORD_W)) u_framer (
      .clk        (clk),
      .rst_n      (rst_n),
      .strobe     (bit_strobe),
      .rx_bit     (rx_bit),
      .sync_en    (mode.sync_en),
      .sync_word  (sync_word),
      .word_valid (word_valid),
      .word_data  (word_data),
      .sync_hit   (sync_hit)
   );
endmodule

// File: rtl/fwf_checker.sv
module fwf_checker (
   input logic        clk,
   input logic        rst_n,
   input logic        tick_in,
   input logic        wr_en,
   input logic        bit_strobe,
   input logic [15:0] ctrl_rdata,
   input logic        word_valid,
   input logic        sync_hit
);
   AST_CTRL_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n) !ctrl_rdata[15]); // R3
   AST_CTRL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) !$past(wr_en) |-> $stable(ctrl_rdata)); // R2
   AST_STROBE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n) bit_strobe |-> tick_in); // R4
   AST_WORD_FOLLOWS_STROBE: assert property (@(posedge clk) disable iff (!rst_n) word_valid |-> $past(bit_strobe)); // R7
   AST_WORD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) word_valid |=> !word_valid); // R7
   AST_WORD_OR_SYNC: assert property (@(posedge clk) disable iff (!rst_n) !(word_valid && sync_hit)); // R8
   AST_SYNC_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n) sync_hit |-> $past(ctrl_rdata[10])); // R9
endmodule

bind fdd_word_framer fwf_checker u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .tick_in    (tick_in),
   .wr_en      (wr_en),
   .bit_strobe (bit_strobe),
   .ctrl_rdata (ctrl_rdata),
   .word_valid (word_valid),
   .sync_hit   (sync_hit)
);

// File: tb/sim_fdd_word_framer.sv
`timescale 1ns/1ps
module sim_fdd_word_framer;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick_in = 1'b0;
   logic        rx_bit = 1'b0;
   logic        wr_en = 1'b0;
   logic        wr_sel = 1'b0;
   logic [15:0] wr_data = '0;
   logic [15:0] ctrl_rdata;
   logic        bit_strobe;
   logic        word_valid;
   logic [15:0] word_data;
   logic        sync_hit;

   int errors = 0;
   int checks = 0;
   int cyc = 0;
   bit done = 1'b0;

   logic [15:0] exp_ctrl = '0;
   logic [15:0] exp_sync = '0;
   logic [15:0] m_shift = '0;
   int          m_cnt = 0;
   bit          adv = 1'b0;
   logic [16:0] exp_q[$];
   logic        bits_q[$];
   int          words_seen = 0;
   int          syncs_seen = 0;
   bit          want_after = 1'b0;
   logic [15:0] after_sync = '0;

   fdd_word_framer u0 (
      .clk(clk), .rst_n(rst_n), .tick_in(tick_in), .rx_bit(rx_bit),
      .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .ctrl_rdata(ctrl_rdata), .bit_strobe(bit_strobe),
      .word_valid(word_valid), .word_data(word_data), .sync_hit(sync_hit)
   );

   always #5 clk = ~clk;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // tick: one pulse every fourth clock, changed just after the rising edge
   initial begin
      int ph = 0;
      forever begin
         @(posedge clk);
         cyc++;
         #1;
         tick_in = (ph == 0);
         ph = (ph + 1) % 4;
      end
   end

   // reference model: follows the requirements and feeds rx_bit
   initial begin
      forever begin
         @(negedge clk);
         if (adv) begin
            rx_bit = (bits_q.size() > 0) ? bits_q.pop_front() : 1'b0;
            adv = 1'b0;
         end
         if (rst_n && bit_strobe) begin
            m_shift = {m_shift[14:0], rx_bit};
            if (exp_ctrl[10] && m_shift == exp_sync) begin
               exp_q.push_back(17'h10000);
               m_cnt = 0;
            end else begin
               m_cnt++;
               if (m_cnt == 16) begin
                  m_cnt = 0;
                  exp_q.push_back({1'b0, m_shift});
               end
            end
            adv = 1'b1;
         end
      end
   end

   // monitor: pops expected items as results appear
   initial begin
      forever begin
         @(negedge clk);
         if (word_valid) begin
            logic [16:0] e;
            e = (exp_q.size() > 0) ? exp_q.pop_front() : 17'h1FFFF;
            chk(e == {1'b0, word_data}, "R6 R7 word", int'(word_data), int'(e));
            words_seen++;
            if (want_after) begin
               after_sync = word_data;
               want_after = 1'b0;
            end
         end
         if (sync_hit) begin
            logic [16:0] e;
            e = (exp_q.size() > 0) ? exp_q.pop_front() : 17'h1FFFF;
            chk(e == 17'h10000, "R8 R9 sync", 32'h10000, int'(e));
            syncs_seen++;
            want_after = 1'b1;
         end
      end
   end

   task automatic reg_write(input bit sel, input logic [15:0] d);
      do @(negedge clk); while (!tick_in);
      wr_en = 1'b1; wr_sel = sel; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0; wr_data = '0;
      if (sel) exp_sync = d;
      else if (d[15]) exp_ctrl = exp_ctrl | (d & 16'h7FFF);
      else exp_ctrl = exp_ctrl & ~(d & 16'h7FFF);
   endtask

   task automatic ticks_to_strobe(output int n);
      n = 0;
      forever begin
         @(negedge clk);
         if (tick_in) n++;
         if (bit_strobe) break;
      end
   endtask

   task automatic strobe_gap(output int g);
      int c0;
      do @(negedge clk); while (!bit_strobe);
      c0 = cyc;
      do @(negedge clk); while (!bit_strobe);
      g = cyc - c0;
   endtask

   task automatic push_word(input logic [15:0] w);
      for (int i = 15; i >= 0; i--) bits_q.push_back(w[i]);
   endtask

   task automatic drain();
      wait (bits_q.size() == 0);
      repeat (20) begin
         do @(negedge clk); while (!bit_strobe);
      end
   endtask

   initial begin
      int n;
      int g;
      int s0;
      int w0;
      repeat (5) @(negedge clk);
      chk(ctrl_rdata == 16'h0, "R1 ctrl", int'(ctrl_rdata), 0);
      chk(!word_valid && !sync_hit && !bit_strobe, "R1 outputs", {word_valid, sync_hit, bit_strobe}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(ctrl_rdata == 16'h0, "R1 ctrl after release", int'(ctrl_rdata), 0);

      reg_write(1'b0, 16'hF600);
      chk(ctrl_rdata == 16'h7600, "R2 set", int'(ctrl_rdata), 16'h7600);
      reg_write(1'b0, 16'h0200);
      chk(ctrl_rdata == 16'h7400, "R2 clear", int'(ctrl_rdata), 16'h7400);
      reg_write(1'b0, 16'h8000);
      chk(ctrl_rdata == 16'h7400, "R2 empty set", int'(ctrl_rdata), 16'h7400);
      reg_write(1'b0, 16'h0000);
      chk(ctrl_rdata == 16'h7400, "R2 empty clear", int'(ctrl_rdata), 16'h7400);
      reg_write(1'b1, 16'hFFFF);
      chk(ctrl_rdata == 16'h7400, "R10 sync write", int'(ctrl_rdata), 16'h7400);
      reg_write(1'b0, 16'h7FFF);
      chk(ctrl_rdata == 16'h0000, "R2 clear all", int'(ctrl_rdata), 0);
      reg_write(1'b0, 16'hFFFF);
      chk(ctrl_rdata == 16'h7FFF, "R3 top bit", int'(ctrl_rdata), 16'h7FFF);
      reg_write(1'b0, 16'h7FFF);
      chk(ctrl_rdata == 16'h0000, "R2 clear again", int'(ctrl_rdata), 0);

      reg_write(1'b0, 16'h8100);
      ticks_to_strobe(n);
      chk(n == 2, "R5 restart short", n, 2);
      strobe_gap(g);
      chk(g == 8, "R4 short gap", g, 8);
      reg_write(1'b0, 16'h0100);
      ticks_to_strobe(n);
      chk(n == 4, "R5 restart long", n, 4);
      strobe_gap(g);
      chk(g == 16, "R4 long gap", g, 16);

      reg_write(1'b0, 16'h8100);
      w0 = words_seen;
      push_word(16'hC0DE); push_word(16'h8001); push_word(16'h5A3C);
      drain();
      chk(words_seen - w0 >= 3, "R7 words", words_seen - w0, 3);

      reg_write(1'b1, 16'h4489);
      reg_write(1'b0, 16'h8400);
      s0 = syncs_seen;
      bits_q.push_back(1'b1); bits_q.push_back(1'b0); bits_q.push_back(1'b1);
      bits_q.push_back(1'b1); bits_q.push_back(1'b0);
      push_word(16'h4489); push_word(16'hA5C3); push_word(16'h1234);
      drain();
      chk(syncs_seen - s0 == 1, "R8 one match", syncs_seen - s0, 1);
      chk(after_sync == 16'hA5C3, "R8 realigned word", int'(after_sync), 16'hA5C3);

      reg_write(1'b0, 16'h0400);
      s0 = syncs_seen;
      bits_q.push_back(1'b1); bits_q.push_back(1'b1); bits_q.push_back(1'b0);
      push_word(16'h4489); push_word(16'h4489);
      drain();
      chk(syncs_seen == s0, "R9 no match when off", syncs_seen - s0, 0);
      chk(exp_q.size() == 0, "R6 queue empty", exp_q.size(), 0);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule